// File: doc/BRIEF.md
# Serial Paged-Flash Read Responder

This block is the device end of a serial read path for a paged flash store. A host clocks commands in on `si` while `cs_n` is low. The block takes bits on the rising edge of `sck` and shifts its answer out on `so`, most significant bit first. It changes `so` only after falling edges, so the host can sample on the next rising edge.

Every read command has its own preamble and its own rule for how the byte pointer wraps:

- A continuous read walks across pages and around the whole array.
- A page read stays inside one page.
- A buffer read stays inside one of two page-sized buffers.
- A status read returns an externally supplied status byte.

The main array and both buffers live outside the block and are reached through synchronous read ports. The block prefetches the next byte while the current one is shifting, so consecutive bytes follow with no gap.

All serial pins are oversampled by the system clock `clk` through a two-stage synchronizer. The `sck` high and low phases must each last at least four `clk` cycles. High impedance on the pad is formed from `so` and `so_oe`.

Top module: `flash_rd_responder`

## Requirements
- R1: The 8-bit opcode is taken MSB first on rising `sck` after `cs_n` falls. The codes are decoded as follows:
  - 68h or E8h select a continuous array read.
  - 52h or D2h select a single page read.
  - 54h or D4h select buffer 1 (`buf_sel`=0).
  - 56h or D6h select buffer 2 (`buf_sel`=1).
  - 57h or D7h select a status read.
- R2: Array and page reads take 24 address bits and then 32 dummy bits.
  - In the address word, bit 23 is ignored, bits 22:10 are the page and bits 9:0 are the starting byte.
  - `arr_addr` carries the page in its upper 13 bits and the byte in its lower 10 bits.
  - The first data bit appears on `so` after the falling `sck` edge that follows the last dummy bit. Bytes go out MSB first.
- R3: A continuous read moves from byte 527 of a page to byte 0 of the next page without extra clocks.
- R4: A continuous read continues at page 0, byte 0 after page 8191, byte 527.
- R5: A page read continues at byte 0 of the same page after byte 527.
- R6: A buffer read takes 14 ignored bits, 10 byte-address bits and then 8 ignored bits. It continues at byte 0 of the same buffer after byte 527.
- R7: A status read outputs the `status` input byte directly after the opcode. It repeats that byte for as long as clocks continue.
- R8: After an unrecognised opcode, `so_oe` stays low for the rest of the selection, whatever bits follow. After `cs_n` goes high and then low again, a new command is accepted.
- R9: `so_oe` is low during the opcode and preamble and after reset. It goes low within four `clk` cycles of `cs_n` going high. `so` changes only after a falling `sck` edge.
- R10: Each output byte causes exactly one single-cycle storage read request, and the array and buffer ports are never requested in the same cycle. Read data is taken one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| arr_rd_en | output | 1 | Main array read request |
| arr_addr | output | 23 | Main array address {page, byte} |
| arr_rdata | input | 8 | Main array data, valid one cycle after request |
| buf_rd_en | output | 1 | Buffer read request |
| buf_sel | output | 1 | Buffer select: 0 = buffer 1, 1 = buffer 2 |
| buf_addr | output | 10 | Buffer byte address |
| buf_rdata | input | 8 | Buffer data, valid one cycle after request |
| status | input | 8 | Status byte returned by the status read |

## Verification
The bound checker watches several properties on every cycle:
- the output enable drops once select has been high long enough;
- `so` and the enable move only after a falling serial edge;
- storage requests are single-cycle pulses that never hit both ports together.

The rules that the checker cannot see are shown only by the bench's scenarios. These are the wrap rules at page, array and buffer ends, the preamble length of each command, the ignored reserved and dummy bits, the handling of unknown opcodes and the byte order. The bench reconstructs the expected bytes from its own storage model.

// File: rtl/flash_rd_pkg.sv
// Shared command and state types for the serial flash read responder.
package flash_rd_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CONT,
        CMD_PAGE,
        CMD_BUF1,
        CMD_BUF2,
        CMD_STAT
    } cmd_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADR,
        ST_DUM,
        ST_DAT,
        ST_IGN
    } st_e;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer for the serial input pins.
// Assumes the pins are asynchronous to clk. Each bit resets to RST_VAL.
module spi_in_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rd_cmd_decode.sv
// Maps an 8-bit opcode onto a read command kind. Unlisted codes yield CMD_NONE.
module rd_cmd_decode
    import flash_rd_pkg::*;
(
    input  logic [7:0] opcode_i,
    output cmd_e       cmd_o
);
    // Pure table lookup of the supported read opcodes.
    always_comb begin
        unique case (opcode_i)
            8'h68, 8'hE8: cmd_o = CMD_CONT;
            8'h52, 8'hD2: cmd_o = CMD_PAGE;
            8'h54, 8'hD4: cmd_o = CMD_BUF1;
            8'h56, 8'hD6: cmd_o = CMD_BUF2;
            8'h57, 8'hD7: cmd_o = CMD_STAT;
            default:      cmd_o = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/rd_addr_step.sv
// Computes the byte pointer that follows the current one under the wrap rule
// of the active command. Assumes byte_i never exceeds PAGE_BYTES-1 by more
// than the host allows; any byte at or past the end wraps.
module rd_addr_step
    import flash_rd_pkg::*;
#(
    parameter int PAGES      = 8192,
    parameter int PAGE_BYTES = 528
) (
    input  cmd_e                          cmd_i,
    input  logic [$clog2(PAGES)-1:0]      page_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_i,
    output logic [$clog2(PAGES)-1:0]      page_o,
    output logic [$clog2(PAGE_BYTES)-1:0] byte_o
);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int BYTE_W = $clog2(PAGE_BYTES);

    logic at_end;
    assign at_end = (byte_i >= BYTE_W'(PAGE_BYTES - 1));

    // Advance the byte; only a continuous read carries into the page number.
    always_comb begin
        page_o = page_i;
        byte_o = byte_i + 1'b1;
        if (cmd_i == CMD_STAT) begin
            byte_o = byte_i;
        end else if (at_end) begin
            byte_o = '0;
            if (cmd_i == CMD_CONT)
                page_o = (page_i == PAGE_W'(PAGES - 1)) ? '0 : page_i + 1'b1;
        end
    end
endmodule

// File: rtl/flash_rd_responder.sv
// Device-side responder for serial paged-flash read commands.
// Oversamples sck/cs_n/si on clk and decodes the opcode. Gathers address
// and dummy bits, prefetches bytes from external synchronous storage and
// shifts them out MSB first on falling sck.
// Assumes sck high and low phases each last at least 4 clk cycles.
module flash_rd_responder
    import flash_rd_pkg::*;
#(
    parameter int PAGES      = 8192,
    parameter int PAGE_BYTES = 528,
    parameter int ARR_DUMMY  = 32,
    parameter int BUF_DUMMY  = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       sck,
    input  logic                                       cs_n,
    input  logic                                       si,
    output logic                                       so,
    output logic                                       so_oe,
    output logic                                       arr_rd_en,
    output logic [$clog2(PAGES)+$clog2(PAGE_BYTES)-1:0] arr_addr,
    input  logic [7:0]                                 arr_rdata,
    output logic                                       buf_rd_en,
    output logic                                       buf_sel,
    output logic [$clog2(PAGE_BYTES)-1:0]              buf_addr,
    input  logic [7:0]                                 buf_rdata,
    input  logic [7:0]                                 status
);
    localparam int PAGE_W   = $clog2(PAGES);
    localparam int BYTE_W   = $clog2(PAGE_BYTES);
    localparam int ADR_BITS = 1 + PAGE_W + BYTE_W;
    localparam int CNT_W    = $clog2(ARR_DUMMY + ADR_BITS);

    logic [2:0] syn;
    logic       sck_s, cs_s, si_s, sck_q, rise, fall;

    spi_in_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck, cs_n, si}),
        .q_o   (syn)
    );
    assign sck_s = syn[2];
    assign cs_s  = syn[1];
    assign si_s  = syn[0];

    // Remember the previous synchronized sck to find its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end
    assign rise = sck_s & ~sck_q;
    assign fall = ~sck_s & sck_q;

    st_e                   state;
    cmd_e                  cmd_q, dec_cmd, fetch_cmd;
    logic [CNT_W-1:0]      cnt, dum_last;
    logic [6:0]            op_sr;
    logic [ADR_BITS-3:0]   adr_sr;
    logic [ADR_BITS-2:0]   adr_word;
    logic [PAGE_W-1:0]     page_q, page_nx;
    logic [BYTE_W-1:0]     byte_q, byte_nx;
    logic [7:0]            sh, next_byte;
    logic [2:0]            bit_idx;
    logic                  stat_req, pend_a, pend_b, pend_s;
    logic                  op_done, adr_done, dum_done, byte_start, do_fetch;

    rd_cmd_decode u_dec (
        .opcode_i ({op_sr, si_s}),
        .cmd_o    (dec_cmd)
    );

    rd_addr_step #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_step (
        .cmd_i  (cmd_q),
        .page_i (page_q),
        .byte_i (byte_q),
        .page_o (page_nx),
        .byte_o (byte_nx)
    );

    assign adr_word   = {adr_sr, si_s};
    assign dum_last   = (cmd_q == CMD_BUF1 || cmd_q == CMD_BUF2) ? CNT_W'(BUF_DUMMY - 1)
                                                                 : CNT_W'(ARR_DUMMY - 1);
    assign op_done    = (state == ST_OPC) && rise && (cnt == CNT_W'(7));
    assign adr_done   = (state == ST_ADR) && rise && (cnt == CNT_W'(ADR_BITS - 1));
    assign dum_done   = (state == ST_DUM) && rise && (cnt == dum_last);
    assign byte_start = (state == ST_DAT) && fall && (bit_idx == 3'd0);
    assign do_fetch   = !cs_s && ((op_done && dec_cmd == CMD_STAT) || dum_done || byte_start);
    assign fetch_cmd  = op_done ? dec_cmd : cmd_q;

    // Command phase sequencing and byte pointer upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OPC;
            cmd_q  <= CMD_NONE;
            cnt    <= '0;
            op_sr  <= '0;
            adr_sr <= '0;
            page_q <= '0;
            byte_q <= '0;
        end else if (cs_s) begin
            state <= ST_OPC;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_OPC: if (rise) begin
                    op_sr <= {op_sr[5:0], si_s};
                    cnt   <= cnt + 1'b1;
                    if (op_done) begin
                        cnt   <= '0;
                        cmd_q <= dec_cmd;
                        if (dec_cmd == CMD_NONE)      state <= ST_IGN;
                        else if (dec_cmd == CMD_STAT) state <= ST_DAT;
                        else                          state <= ST_ADR;
                    end
                end
                ST_ADR: if (rise) begin
                    adr_sr <= adr_word[ADR_BITS-3:0];
                    cnt    <= cnt + 1'b1;
                    if (adr_done) begin
                        cnt    <= '0;
                        state  <= ST_DUM;
                        page_q <= adr_word[PAGE_W+BYTE_W-1:BYTE_W];
                        byte_q <= adr_word[BYTE_W-1:0];
                    end
                end
                ST_DUM: if (rise) begin
                    cnt <= cnt + 1'b1;
                    if (dum_done) begin
                        cnt   <= '0;
                        state <= ST_DAT;
                    end
                end
                default: ;
            endcase
            if (do_fetch) begin
                page_q <= page_nx;
                byte_q <= byte_nx;
            end
        end
    end

    // Issue one storage read per byte on the port the command selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_rd_en <= 1'b0;
            buf_rd_en <= 1'b0;
            stat_req  <= 1'b0;
            arr_addr  <= '0;
            buf_addr  <= '0;
            buf_sel   <= 1'b0;
        end else begin
            arr_rd_en <= do_fetch && (fetch_cmd == CMD_CONT || fetch_cmd == CMD_PAGE);
            buf_rd_en <= do_fetch && (fetch_cmd == CMD_BUF1 || fetch_cmd == CMD_BUF2);
            stat_req  <= do_fetch && (fetch_cmd == CMD_STAT);
            if (do_fetch) begin
                arr_addr <= {page_q, byte_q};
                buf_addr <= byte_q;
                buf_sel  <= (fetch_cmd == CMD_BUF2);
            end
        end
    end

    // Capture the returned byte one cycle after its request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a    <= 1'b0;
            pend_b    <= 1'b0;
            pend_s    <= 1'b0;
            next_byte <= '0;
        end else begin
            pend_a <= arr_rd_en;
            pend_b <= buf_rd_en;
            pend_s <= stat_req;
            if (pend_a)      next_byte <= arr_rdata;
            else if (pend_b) next_byte <= buf_rdata;
            else if (pend_s) next_byte <= status;
        end
    end

    // Shift data out on falling sck; drop the enable when select goes high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_idx <= '0;
            so_oe   <= 1'b0;
        end else if (cs_s) begin
            bit_idx <= '0;
            so_oe   <= 1'b0;
        end else if (state == ST_DAT && fall) begin
            if (bit_idx == 3'd0) begin
                sh      <= next_byte;
                bit_idx <= 3'd7;
                so_oe   <= 1'b1;
            end else begin
                sh      <= {sh[6:0], 1'b0};
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    assign so = sh[7];
endmodule

// File: rtl/flash_rd_responder_chk.sv
// Cycle-level properties of the read responder, attached by bind.
// Assumes the two-stage pin synchronizer of the top module.
module flash_rd_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so,
    input logic so_oe,
    input logic sck_fall,
    input logic arr_rd_en,
    input logic buf_rd_en
);
    // Both storage ports never requested together.
    assert_single_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && buf_rd_en));

    // Array requests are one-cycle pulses.
    assert_arr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |=> !arr_rd_en);

    // Buffer requests are one-cycle pulses.
    assert_buf_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> !buf_rd_en);

    // Enable off once select has been high for four cycles.
    assert_oe_off_desel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    // Data line moves only after a falling serial edge.
    assert_so_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so) |-> $past(sck_fall));

    // Enable comes on only at a falling serial edge.
    assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall));
endmodule

bind flash_rd_responder flash_rd_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .so        (so),
    .so_oe     (so_oe),
    .sck_fall  (fall),
    .arr_rd_en (arr_rd_en),
    .buf_rd_en (buf_rd_en)
);

// File: tb/tb_flash_rd_responder.sv
// Directed bench for the serial flash read responder.
module tb_flash_rd_responder;
    localparam int HALF  = 5;
    localparam int NPAGE = 8192;
    localparam int NBYTE = 528;

    logic        clk = 1'b0;
    logic        rst_n, sck, cs_n, si;
    logic        so, so_oe, arr_rd_en, buf_rd_en, buf_sel;
    logic [22:0] arr_addr;
    logic [9:0]  buf_addr;
    logic [7:0]  arr_rdata, buf_rdata, status;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    flash_rd_responder dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe),
        .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .buf_rd_en(buf_rd_en), .buf_sel(buf_sel), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .status(status)
    );

    function automatic logic [7:0] arr_val(input logic [22:0] a);
        return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] buf_val(input logic s, input logic [9:0] a);
        return a[7:0] ^ {6'd0, a[9:8]} ^ (s ? 8'hC3 : 8'h3C);
    endfunction

    // Storage model: synchronous read, one cycle latency.
    always_ff @(posedge clk) begin
        if (arr_rd_en) arr_rdata <= arr_val(arr_addr);
        if (buf_rd_en) buf_rdata <= buf_val(buf_sel, buf_addr);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One serial bit: drive si low phase, sample so/oe just before the rise.
    task automatic xbit(input logic b, output logic r, output logic oe);
        si = b; sck = 1'b0; tick(HALF);
        r = so; oe = so_oe;
        sck = 1'b1; tick(HALF);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, output logic any_oe);
        logic r, oe;
        any_oe = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            xbit(v[i], r, oe);
            any_oe |= oe;
        end
    endtask

    task automatic recv_byte(output logic [7:0] d, output logic all_oe);
        logic r, oe;
        all_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b0, r, oe);
            d[i] = r;
            all_oe &= oe;
        end
    endtask

    task automatic deselect();
        sck = 1'b0; tick(2); cs_n = 1'b1; tick(8);
    endtask

    // kind: 0 continuous, 1 page, 2 buffer. Checks preamble enable and data.
    task automatic run_read(input logic [7:0] op, input int kind, input logic [23:0] a24,
                            input int n, input string tag);
        logic       any_oe, all_oe, sel;
        logic [7:0] d, e;
        int         pg, by;
        pg  = int'(a24[22:10]);
        by  = int'(a24[9:0]);
        sel = (op == 8'h56 || op == 8'hD6);
        cs_n = 1'b0; tick(3);
        send_bits({24'd0, op}, 8, any_oe);
        check(!any_oe, {tag, " R9 opcode oe"}, any_oe, 0);
        send_bits({8'd0, a24}, 24, any_oe);
        check(!any_oe, {tag, " R9 address oe"}, any_oe, 0);
        send_bits(32'hFFFF_FFFF, (kind == 2) ? 8 : 32, any_oe);
        check(!any_oe, {tag, " R9 dummy oe"}, any_oe, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, all_oe);
            e = (kind == 2) ? buf_val(sel, by[9:0]) : arr_val({pg[12:0], by[9:0]});
            check(d == e && all_oe, tag, {all_oe, d}, {1'b1, e});
            if (by == NBYTE - 1) begin
                by = 0;
                if (kind == 0) pg = (pg == NPAGE - 1) ? 0 : pg + 1;
            end else begin
                by++;
            end
        end
        deselect();
        check(!so_oe, {tag, " R9 oe after deselect"}, so_oe, 0);
    endtask

    task automatic t_reset();
        check(!so_oe, "R9 reset oe", so_oe, 0);
        check(!arr_rd_en && !buf_rd_en, "R10 reset requests", {arr_rd_en, buf_rd_en}, 0);
    endtask

    task automatic t_status(input logic [7:0] op, input logic [7:0] v);
        logic       any_oe, all_oe;
        logic [7:0] d;
        status = v;
        cs_n = 1'b0; tick(3);
        send_bits({24'd0, op}, 8, any_oe);
        for (int k = 0; k < 2; k++) begin
            recv_byte(d, all_oe);
            check(d == v && all_oe, "R7 status byte", {all_oe, d}, {1'b1, v});
        end
        deselect();
    endtask

    task automatic t_unknown();
        logic any_oe, a2;
        cs_n = 1'b0; tick(3);
        send_bits(32'h0000_0011, 8, any_oe);
        send_bits({24'd0, 8'h68}, 8, a2);
        any_oe |= a2;
        send_bits(32'hFFFF_FFFF, 32, a2);
        any_oe |= a2;
        check(!any_oe, "R8 unknown opcode keeps so off", any_oe, 0);
        deselect();
        run_read(8'h68, 0, {1'b0, 13'd21, 10'd300}, 2, "R8 new command after deselect");
    endtask

    task automatic t_abort();
        logic       any_oe, all_oe;
        logic [7:0] d;
        cs_n = 1'b0; tick(3);
        send_bits({24'd0, 8'hE8}, 8, any_oe);
        send_bits({8'd0, 1'b0, 13'd9, 10'd4}, 24, any_oe);
        send_bits(32'd0, 32, any_oe);
        recv_byte(d, all_oe);
        check(all_oe, "R9 oe during data", all_oe, 1);
        si = 1'b0; sck = 1'b0; tick(HALF);
        cs_n = 1'b1; tick(5);
        check(!so_oe, "R9 oe off after select rises mid-read", so_oe, 0);
        tick(5);
    endtask

    initial begin
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; status = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        run_read(8'h68, 0, {1'b0, 13'd5, 10'd10},     4, "R2 continuous start");
        run_read(8'h68, 0, {1'b1, 13'd5, 10'd10},     2, "R2 reserved bit ignored");
        run_read(8'hE8, 0, {1'b0, 13'd7, 10'd526},    4, "R3 page crossing");
        run_read(8'h68, 0, {1'b0, 13'd8191, 10'd526}, 3, "R4 array wrap");
        run_read(8'h52, 1, {1'b0, 13'd3, 10'd526},    4, "R5 page wrap");
        run_read(8'hD2, 1, {1'b0, 13'd100, 10'd0},    2, "R1 alternate page opcode");
        run_read(8'h54, 2, {14'h3FFF, 10'd526},       4, "R6 buffer 1 wrap");
        run_read(8'hD6, 2, {14'h0000, 10'd526},       4, "R6 buffer 2 wrap");
        run_read(8'hD4, 2, {14'h1234, 10'd17},        2, "R1 alternate buffer 1 opcode");
        run_read(8'h56, 2, {14'h0000, 10'd0},         2, "R1 buffer 2 opcode");
        t_status(8'hD7, 8'hA5);
        t_status(8'h57, 8'h3C);
        t_unknown();
        t_abort();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule